// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the software-visible register slave of a color LCD controller. A host reaches it over a simple single-cycle read/write bus that carries a word index rather than a byte address. Behind that bus sit four display timing words, an upper and a lower frame base, an interrupt mask, a control word, raw and masked interrupt status, and two current-address readbacks. It also has a 128-word palette window, which stores and returns whatever software writes, and a read-only identification window of eight bytes.

The control word drives the display side directly. Its outputs are the enable, power, bits-per-pixel mode and the two big-endian ordering modes. A combined display-on flag is high only when enable and power are both set. The upper frame base is also driven out to the display side.

Every bus write raises a sticky invalidate request, whatever the target of the write. The display side clears that request with an acknowledge after it has redrawn the full frame. Pixel fetch, vertical timing and interrupt sources are outside this block, so the raw status is tied to zero.

Top module: `lcdc_regs`

## Requirements
- R1: After reset, every register and every palette word reads zero, and `disp_on`, `ctl_enable`, `ctl_power` and `inval_pending` are low.
- R2: The control word sits at word index 7. Its fields are: bit 0 enable, bits 3:1 bits-per-pixel mode, bit 9 big-endian byte order, bit 10 big-endian pixel order, bit 11 power. The matching outputs show a written value from the cycle after the write.
- R3: `disp_on` is high exactly when control bit 0 and control bit 11 are both set.
- R4: Word indices 0 to 3 (timing 0 to 3), 4 (upper base), 5 (lower base) and 7 (control) store all 32 bits and read them back. Index 6 (interrupt mask) keeps only its low 5 bits and reads with the upper bits zero. `frame_base` drives the upper base.
- R5: Raw status (index 8) reads zero. Masked status (index 9) reads raw status AND mask, which is zero. Writes to indices 8, 9, 11 and 12 change no stored value.
- R6: Index 11 reads the upper base and index 12 reads the lower base.
- R7: Word indices 0x3F8 to 0x3FF read one identification byte each, in bits 7:0 with the upper bits zero: 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Writes to this window have no effect.
- R8: Word indices 0x080 to 0x0FF address 128 palette words, and each palette word reads back exactly as written.
- R9: A read of any unmapped index returns zero and pulses `bus_rderr` for one cycle. Unmapped indices are 10, 13 to 0x07F, and 0x100 to 0x3F7. Reads of mapped indices leave `bus_rderr` low.
- R10: Any write, including one to a read-only or unmapped index, sets `inval_pending`. Reads never set it.
- R11: `inval_ack` clears `inval_pending`. If a write and an acknowledge arrive in the same cycle, the write wins and the flag stays set.
- R12: Read data and `bus_rderr` appear on the clock edge that samples the read request, and are valid until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 10 | Word index (byte offset divided by 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rderr | output | 1 | One-cycle pulse for an unmapped read |
| ctl_enable | output | 1 | Control enable bit |
| ctl_bpp | output | 3 | Bits-per-pixel mode field |
| ctl_be_bytes | output | 1 | Big-endian byte order |
| ctl_be_pixels | output | 1 | Big-endian pixel order within a byte |
| ctl_power | output | 1 | Control power bit |
| frame_base | output | 32 | Upper frame base address |
| disp_on | output | 1 | Enable AND power |
| inval_pending | output | 1 | Sticky full-frame redraw request |
| inval_ack | input | 1 | Display side clears the request |

## Verification
A wrong address decode shows up on the next read. The value comes back from the wrong register or as zero, or `bus_rderr` fires on a mapped index or fails to fire on an unmapped one, so a sweep of all 1024 word indices finds it within two cycles per index. A corrupted control or base register shows on `disp_on`, on the mode outputs or on `frame_base` one cycle after the write. A faulty invalidate flag shows on `inval_pending` one cycle after a write or an acknowledge.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  localparam int WORD_W = 10;
  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    RG_NONE, RG_TIMING, RG_UBASE, RG_LBASE, RG_IMASK, RG_CTRL,
    RG_RAW, RG_MASKED, RG_UCUR, RG_LCUR, RG_PAL, RG_ID
  } region_e;

  // map a word index to the register region it selects
  function automatic region_e decode_word(input logic [WORD_W-1:0] w);
    region_e r;
    r = RG_NONE;
    if (w[9:7] == 3'b001)       r = RG_PAL;
    else if (w[9:3] == 7'h7F)   r = RG_ID;
    else if (w[9:4] == 6'd0) begin
      case (w[3:0])
        4'd0, 4'd1, 4'd2, 4'd3: r = RG_TIMING;
        4'd4:  r = RG_UBASE;
        4'd5:  r = RG_LBASE;
        4'd6:  r = RG_IMASK;
        4'd7:  r = RG_CTRL;
        4'd8:  r = RG_RAW;
        4'd9:  r = RG_MASKED;
        4'd11: r = RG_UCUR;
        4'd12: r = RG_LCUR;
        default: r = RG_NONE;
      endcase
    end
    return r;
  endfunction

  // identification byte for slot 0..7
  function automatic logic [7:0] id_byte(input logic [2:0] slot);
    logic [7:0] b;
    case (slot)
      3'd0: b = 8'h10;
      3'd1: b = 8'h11;
      3'd2: b = 8'h04;
      3'd3: b = 8'h00;
      3'd4: b = 8'h0D;
      3'd5: b = 8'hF0;
      3'd6: b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

  function automatic logic display_live(input logic [DATA_W-1:0] ctrl);
    return ctrl[0] & ctrl[11];
  endfunction

endpackage

// File: rtl/lcdc_ctrl_file.sv
module lcdc_ctrl_file
  import lcdc_pkg::*;
#(
  parameter int INT_W = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  region_e                region,
  input  logic [1:0]             tsel,
  input  logic [DATA_W-1:0]      wdata,
  output logic [3:0][DATA_W-1:0] timing_q,
  output logic [DATA_W-1:0]      ubase_q,
  output logic [DATA_W-1:0]      lbase_q,
  output logic [INT_W-1:0]       imask_q,
  output logic [DATA_W-1:0]      ctrl_q
);

  localparam int NTIM = 4;

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    logic hit;
    assign hit = wr_en && (region == RG_TIMING) && (tsel == g[1:0]);
    always_ff @(posedge clk) begin
      if (!rst_n)   timing_q[g] <= '0;
      else if (hit) timing_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ubase_q <= '0;
      lbase_q <= '0;
      imask_q <= '0;
      ctrl_q  <= '0;
    end else if (wr_en) begin
      case (region)
        RG_UBASE: ubase_q <= wdata;
        RG_LBASE: lbase_q <= wdata;
        RG_IMASK: imask_q <= wdata[INT_W-1:0];
        RG_CTRL:  ctrl_q  <= wdata;
        default: ;
      endcase
    end
  end

  // R5
  ro_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (region == RG_RAW || region == RG_MASKED || region == RG_UCUR ||
               region == RG_LCUR || region == RG_ID || region == RG_NONE))
    |=> ($stable(ubase_q) && $stable(lbase_q) && $stable(ctrl_q) && $stable(imask_q)));

endmodule

// File: rtl/lcdc_palette.sv
module lcdc_palette
  import lcdc_pkg::*;
#(
  parameter int WORDS = 128,
  localparam int AW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_word
);

  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wdata;
    end
  end

  assign rd_word = mem[rd_idx];

  // R8
  pal_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=> (rd_word == $past(wdata)) || (rd_idx != $past(rd_idx)));

endmodule

// File: rtl/lcdc_inval.sv
module lcdc_inval (
  input  logic clk,
  input  logic rst_n,
  input  logic any_wr,
  input  logic ack,
  output logic pending
);

  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 1'b0;
    else if (any_wr) pending <= 1'b1;
    else if (ack)    pending <= 1'b0;
  end

  // R10
  inval_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_wr |=> pending);

  // R11
  inval_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_wr && ack) |=> !pending);

  // R10
  inval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_wr && !ack) |=> $stable(pending));

endmodule

// File: rtl/lcdc_regs.sv
module lcdc_regs
  import lcdc_pkg::*;
#(
  parameter int INT_W     = 5,
  parameter int PAL_WORDS = 128,
  localparam int PAL_AW   = $clog2(PAL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [WORD_W-1:0] bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rderr,
  output logic              ctl_enable,
  output logic [2:0]        ctl_bpp,
  output logic              ctl_be_bytes,
  output logic              ctl_be_pixels,
  output logic              ctl_power,
  output logic [DATA_W-1:0] frame_base,
  output logic              disp_on,
  output logic              inval_pending,
  input  logic              inval_ack
);

  // named internal events
  region_e                region;
  logic                   wr_evt;
  logic                   rd_evt;
  logic                   pal_wr;
  logic                   rd_miss;
  logic [DATA_W-1:0]      rd_mux;

  logic [3:0][DATA_W-1:0] timing_q;
  logic [DATA_W-1:0]      ubase_q;
  logic [DATA_W-1:0]      lbase_q;
  logic [INT_W-1:0]       imask_q;
  logic [DATA_W-1:0]      ctrl_q;
  logic [DATA_W-1:0]      pal_word;
  logic [INT_W-1:0]       raw_status;

  assign region     = decode_word(bus_word);
  assign wr_evt     = bus_valid && bus_write;
  assign rd_evt     = bus_valid && !bus_write;
  assign pal_wr     = wr_evt && (region == RG_PAL);
  assign raw_status = '0;

  lcdc_ctrl_file #(.INT_W(INT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_evt),
    .region   (region),
    .tsel     (bus_word[1:0]),
    .wdata    (bus_wdata),
    .timing_q (timing_q),
    .ubase_q  (ubase_q),
    .lbase_q  (lbase_q),
    .imask_q  (imask_q),
    .ctrl_q   (ctrl_q)
  );

  lcdc_palette #(.WORDS(PAL_WORDS)) u_pal (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pal_wr),
    .wr_idx  (bus_word[PAL_AW-1:0]),
    .wdata   (bus_wdata),
    .rd_idx  (bus_word[PAL_AW-1:0]),
    .rd_word (pal_word)
  );

  lcdc_inval u_inval (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_wr  (wr_evt),
    .ack     (inval_ack),
    .pending (inval_pending)
  );

  always_comb begin
    rd_miss = 1'b0;
    case (region)
      RG_TIMING:         rd_mux = timing_q[bus_word[1:0]];
      RG_UBASE, RG_UCUR: rd_mux = ubase_q;
      RG_LBASE, RG_LCUR: rd_mux = lbase_q;
      RG_IMASK:          rd_mux = {{(DATA_W-INT_W){1'b0}}, imask_q};
      RG_CTRL:           rd_mux = ctrl_q;
      RG_RAW:            rd_mux = {{(DATA_W-INT_W){1'b0}}, raw_status};
      RG_MASKED:         rd_mux = {{(DATA_W-INT_W){1'b0}}, raw_status & imask_q};
      RG_PAL:            rd_mux = pal_word;
      RG_ID:             rd_mux = {{(DATA_W-8){1'b0}}, id_byte(bus_word[2:0])};
      default: begin
        rd_mux  = '0;
        rd_miss = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
      bus_rderr <= 1'b0;
    end else begin
      bus_rderr <= rd_evt && rd_miss;
      if (rd_evt) bus_rdata <= rd_mux;
    end
  end

  assign ctl_enable    = ctrl_q[0];
  assign ctl_bpp       = ctrl_q[3:1];
  assign ctl_be_bytes  = ctrl_q[9];
  assign ctl_be_pixels = ctrl_q[10];
  assign ctl_power     = ctrl_q[11];
  assign disp_on       = display_live(ctrl_q);
  assign frame_base    = ubase_q;

  // R3
  disp_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_word == 10'd7)
    |=> (disp_on == ($past(bus_wdata[0]) && $past(bus_wdata[11]))));

  // R2
  ctrl_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_word == 10'd7)
    |=> (ctl_bpp == $past(bus_wdata[3:1]) && ctl_be_bytes == $past(bus_wdata[9])
         && ctl_be_pixels == $past(bus_wdata[10])));

  // R4
  frame_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && bus_word == 10'd4) |=> (frame_base == $past(bus_wdata)));

  // R9
  rderr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rderr |-> (bus_rdata == '0));

  // R12
  rderr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rderr |-> $past(rd_evt));

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_evt |=> $stable(bus_rdata));

endmodule

// File: tb/lcdc_regs_tb.sv
`timescale 1ns/1ps
module lcdc_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [9:0]  bus_word = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rderr;
  logic        ctl_enable, ctl_be_bytes, ctl_be_pixels, ctl_power;
  logic [2:0]  ctl_bpp;
  logic [31:0] frame_base;
  logic        disp_on, inval_pending;
  logic        inval_ack = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lcdc_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rderr(bus_rderr), .ctl_enable(ctl_enable), .ctl_bpp(ctl_bpp),
    .ctl_be_bytes(ctl_be_bytes), .ctl_be_pixels(ctl_be_pixels),
    .ctl_power(ctl_power), .frame_base(frame_base), .disp_on(disp_on),
    .inval_pending(inval_pending), .inval_ack(inval_ack)
  );

  task automatic chk(input string tag, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] w, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_word = w;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
    e = bus_rderr;
  endtask

  function automatic logic [7:0] idb(input int k);
    logic [7:0] t [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[k];
  endfunction

  function automatic bit unmapped(input int w);
    if (w >= 10'h080 && w <= 10'h0FF) return 0;
    if (w >= 10'h3F8) return 0;
    if (w <= 12 && w != 10) return 0;
    return 1;
  endfunction

  function automatic logic [31:0] pat(input int i);
    return (32'h9E37_79B9 * (i + 3)) ^ (32'h0F0F_0000 >> (i % 5));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic e;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset outputs
    chk("R1 outputs", {25'd0, disp_on, ctl_enable, ctl_power, inval_pending, ctl_bpp, 1'b0},
        33'd0);
    chk("R1 frame_base", {1'b0, frame_base}, 33'd0);

    // R1 R7 R9 R12 full sweep of reset state
    for (int w = 0; w < 1024; w++) begin
      rd(w[9:0], d, e);
      exp = (w >= 10'h3F8) ? {24'd0, idb(w - 10'h3F8)} : 32'd0;
      chk($sformatf("R9/R7/R1 word %0h", w), {e, d}, {unmapped(w), exp});
    end
    // R10 reads do not invalidate
    chk("R10 reads leave inval", {32'd0, inval_pending}, 33'd0);

    // R4 register readback
    for (int i = 0; i < 6; i++) wr(i[9:0], pat(i));
    wr(10'd6, 32'hFFFF_FFFF);
    wr(10'd7, 32'h0000_0E0B);
    chk("R10 write sets inval", {32'd0, inval_pending}, 33'd1);
    for (int i = 0; i < 6; i++) begin
      rd(i[9:0], d, e);
      chk($sformatf("R4 word %0d", i), {e, d}, {1'b0, pat(i)});
    end
    rd(10'd6, d, e); chk("R4 mask width", {e, d}, {1'b0, 32'h1F});
    rd(10'd7, d, e); chk("R2 ctrl readback", {e, d}, {1'b0, 32'h0000_0E0B});
    chk("R4 frame_base", {1'b0, frame_base}, {1'b0, pat(4)});
    // R6 current reads
    rd(10'd11, d, e); chk("R6 upper cur", {e, d}, {1'b0, pat(4)});
    rd(10'd12, d, e); chk("R6 lower cur", {e, d}, {1'b0, pat(5)});
    // R5 status
    rd(10'd8, d, e); chk("R5 raw", {e, d}, 33'd0);
    rd(10'd9, d, e); chk("R5 masked", {e, d}, 33'd0);

    // R5 R7 R9 writes to read-only or unmapped change nothing
    wr(10'd8, 32'hDEAD_BEEF); wr(10'd9, 32'hDEAD_BEEF);
    wr(10'd11, 32'h1234_5678); wr(10'd12, 32'h8765_4321);
    wr(10'd10, 32'hFFFF_FFFF); wr(10'h3FA, 32'hFFFF_FFFF);
    for (int i = 0; i < 8; i++) begin
      rd(i[9:0], d, e);
      exp = (i == 6) ? 32'h1F : (i == 7) ? 32'h0000_0E0B : pat(i);
      chk($sformatf("R5 after ro writes word %0d", i), {e, d}, {1'b0, exp});
    end
    rd(10'd8, d, e);  chk("R5 raw after write", {e, d}, 33'd0);
    rd(10'd11, d, e); chk("R6 ucur after write", {e, d}, {1'b0, pat(4)});
    rd(10'd12, d, e); chk("R6 lcur after write", {e, d}, {1'b0, pat(5)});
    rd(10'h3FA, d, e); chk("R7 id after write", {e, d}, {1'b0, 32'h04});
    rd(10'd10, d, e); chk("R9 unmapped after write", {e, d}, {1'b1, 32'd0});
    @(negedge clk);
    chk("R9 rderr one cycle", {32'd0, bus_rderr}, 33'd0);

    // R2 R3 control field sweep
    for (int c = 0; c < 128; c++) begin
      logic [31:0] cw;
      cw = {20'd0, c[3], c[2], c[1], 5'd0, c[6:4], c[0]};
      wr(10'd7, cw);
      chk($sformatf("R2/R3 ctrl %0h", cw),
          {25'd0, ctl_enable, ctl_bpp, ctl_be_bytes, ctl_be_pixels, ctl_power, disp_on},
          {25'd0, c[0], c[6:4], c[1], c[2], c[3], c[0] & c[3]});
    end

    // R8 palette
    for (int i = 0; i < 128; i++) wr(10'h080 + i[9:0], pat(i + 40));
    for (int i = 0; i < 128; i++) begin
      rd(10'h080 + i[9:0], d, e);
      chk($sformatf("R8 palette %0d", i), {e, d}, {1'b0, pat(i + 40)});
    end
    rd(10'd0, d, e); chk("R8 timing untouched", {e, d}, {1'b0, pat(0)});

    // R11 acknowledge and collision
    @(negedge clk); inval_ack = 1'b1;
    @(negedge clk); inval_ack = 1'b0;
    chk("R11 ack clears", {32'd0, inval_pending}, 33'd0);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_word = 10'd200; bus_wdata = 32'h5;
    inval_ack = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; inval_ack = 1'b0;
    chk("R11 write wins over ack", {32'd0, inval_pending}, 33'd1);
    rd(10'd3, d, e);
    chk("R10 pending held by read", {32'd0, inval_pending}, 33'd1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule